// File: doc/BRIEF.md
# Protection Fault Deglitch and Hiccup Controller

This block sits behind the analog comparators of a power-path switch and decides when a raw fault flag is real. It counts a slow timing tick (nominally 2 MHz, so two ticks per microsecond). Each of ten fault flags has its own filter. A flag counts as qualified only after it has stayed high without a break for that fault's filter time. The bus overvoltage filter has a short and a long setting, chosen by a configuration input.

A qualified fault turns the switch off, sets a sticky event bit and may raise the interrupt. Bus overcurrent handling has two modes. In latch-off mode the switch stays off until the host asks for it again. In hiccup mode the switch is re-enabled by itself after a retry wait. A trip counter records repeated hiccup trips, and it clears once a quiet period passes with no new trip. All configuration arrives as plain input pins.

Event bit positions: 0 bus overvoltage, 1 bus overcurrent, 2 battery overcurrent, 3 dropout overvoltage, 4 battery overvoltage, 5 output overvoltage, 6 reverse current, 7 short circuit, 8 bus thermistor, 9 battery thermistor.

Top module: `fault_guard`

## Requirements
- R1: After reset, `sw_en_o` is 0, all event bits are 0, `irq_o` is 0 and `trip_cnt_o` is 0.
- R2: A fault qualifies after its raw flag is seen high on N consecutive ticks. Any cycle with the flag low restarts the count from zero.
- R3: Filter lengths in ticks are set by parameters. Defaults are: bus overvoltage 16, or 256 when `ov_long_i` is 1; bus overcurrent 16; battery overcurrent 1024; dropout, battery and output overvoltage 128; reverse current 16; short circuit 4; each thermistor 200000.
- R4: On the clock after a fault qualifies, `sw_en_o` is 0.
- R5: When a fault qualifies, its event bit (at the position listed above) is set. The bit stays set until a 1 is written to the same position of `evt_clr_i` for one cycle.
- R6: `irq_o` is 1 exactly when some event bit is set while its `evt_mask_i` bit is 0.
- R7: A one-cycle `host_en_i` pulse sets `sw_en_o` on the next clock. This happens only if no fault is qualified and no hiccup wait is running. Otherwise the pulse has no effect.
- R8: With `hiccup_en_i` at 1, a bus overcurrent trip turns the switch off for HIC_WAIT ticks (default 200000). The switch is then turned back on without a host pulse. The overcurrent filter is held cleared during the wait.
- R9: Each hiccup trip adds one to `trip_cnt_o`. The count returns to 0 HIC_RST ticks (default 800000) after the most recent trip.
- R10: Filter, wait and quiet counters advance only in cycles where `tick_i` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Timing tick enable |
| bus_ov_i | input | 1 | Raw bus overvoltage flag |
| bus_oc_i | input | 1 | Raw bus overcurrent flag |
| bat_oc_i | input | 1 | Raw battery overcurrent flag |
| drop_ov_i | input | 1 | Raw dropout overvoltage flag |
| bat_ov_i | input | 1 | Raw battery overvoltage flag |
| out_ov_i | input | 1 | Raw output overvoltage flag |
| rev_cur_i | input | 1 | Raw reverse current flag |
| short_i | input | 1 | Raw short-circuit flag |
| ts_bus_i | input | 1 | Raw bus thermistor flag |
| ts_bat_i | input | 1 | Raw battery thermistor flag |
| ov_long_i | input | 1 | Selects the long bus overvoltage filter |
| hiccup_en_i | input | 1 | Bus overcurrent response: 1 hiccup, 0 latch-off |
| host_en_i | input | 1 | Host switch-enable pulse |
| evt_clr_i | input | 10 | Write-one-to-clear pulses for event bits |
| evt_mask_i | input | 10 | Interrupt mask per event bit |
| sw_en_o | output | 1 | Switch enable |
| evt_o | output | 10 | Sticky event bits |
| irq_o | output | 1 | Interrupt |
| trip_cnt_o | output | TRIP_W | Hiccup trip count |

## Verification
The bench shrinks every filter length to between 2 and 30 ticks, the retry wait to 40 ticks and the quiet period to 100 ticks. With these values every fault, including the thermistor and battery overcurrent filters, can be driven to its exact qualifying tick. Both sides of that tick are checked. The short values also let the bench see a full hiccup retry and a trip-count clear within a few hundred cycles. A held-low tick shows that nothing counts without the timing base.

// File: rtl/fault_guard_pkg.sv
package fault_guard_pkg;
  localparam int unsigned NFLT = 10;

  typedef enum logic [3:0] {
    F_BUS_OV  = 4'd0,
    F_BUS_OC  = 4'd1,
    F_BAT_OC  = 4'd2,
    F_DROP_OV = 4'd3,
    F_BAT_OV  = 4'd4,
    F_OUT_OV  = 4'd5,
    F_REV     = 4'd6,
    F_SHORT   = 4'd7,
    F_TS_BUS  = 4'd8,
    F_TS_BAT  = 4'd9
  } fault_e;

  typedef logic [NFLT-1:0] fault_vec_t;
endpackage

// File: rtl/fault_deglitch.sv
module fault_deglitch #(
  parameter int unsigned CNT_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             raw_i,
  input  logic             hold_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             qual_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (!raw_i || hold_i) begin
      cnt_q <= '0;
    end else if (tick_i && (cnt_q < limit_i)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign qual_o = raw_i && !hold_i && (cnt_q >= limit_i);
endmodule

// File: rtl/fault_hiccup.sv
module fault_hiccup #(
  parameter int unsigned WAIT_TICKS  = 200000,
  parameter int unsigned QUIET_TICKS = 800000,
  parameter int unsigned TRIP_W      = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              trip_i,
  input  logic              abort_i,
  output logic              wait_o,
  output logic              retry_o,
  output logic [TRIP_W-1:0] trip_cnt_o
);
  localparam int unsigned WAIT_W  = $clog2(WAIT_TICKS + 1);
  localparam int unsigned QUIET_W = $clog2(QUIET_TICKS + 1);
  localparam logic [WAIT_W-1:0]  WAIT_LAST  = WAIT_W'(WAIT_TICKS - 1);
  localparam logic [QUIET_W-1:0] QUIET_LAST = QUIET_W'(QUIET_TICKS - 1);

  logic               wait_q;
  logic [WAIT_W-1:0]  wcnt_q;
  logic [QUIET_W-1:0] qcnt_q;
  logic [TRIP_W-1:0]  trips_q;

  assign retry_o = wait_q && tick_i && !abort_i && (wcnt_q == WAIT_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wait_q <= 1'b0;
      wcnt_q <= '0;
    end else if (abort_i) begin
      wait_q <= 1'b0;
      wcnt_q <= '0;
    end else if (trip_i) begin
      wait_q <= 1'b1;
      wcnt_q <= '0;
    end else if (retry_o) begin
      wait_q <= 1'b0;
      wcnt_q <= '0;
    end else if (wait_q && tick_i) begin
      wcnt_q <= wcnt_q + 1'b1;
    end
  end

  // quiet window restarts on every trip; expiry forgets the history
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      qcnt_q  <= '0;
      trips_q <= '0;
    end else if (trip_i) begin
      qcnt_q  <= '0;
      if (trips_q != {TRIP_W{1'b1}}) trips_q <= trips_q + 1'b1;
    end else if (tick_i && (trips_q != '0)) begin
      if (qcnt_q == QUIET_LAST) begin
        qcnt_q  <= '0;
        trips_q <= '0;
      end else begin
        qcnt_q <= qcnt_q + 1'b1;
      end
    end
  end

  assign wait_o     = wait_q;
  assign trip_cnt_o = trips_q;
endmodule

// File: rtl/fault_events.sv
module fault_events #(
  parameter int unsigned N = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] mask_i,
  output logic [N-1:0] evt_o,
  output logic         irq_o
);
  logic [N-1:0] evt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) evt_q <= '0;
    else         evt_q <= (evt_q & ~clr_i) | set_i;
  end

  assign evt_o = evt_q;
  assign irq_o = |(evt_q & ~mask_i);
endmodule

// File: rtl/fault_guard.sv
module fault_guard
  import fault_guard_pkg::*;
#(
  parameter int unsigned DG_BOV_S  = 16,
  parameter int unsigned DG_BOV_L  = 256,
  parameter int unsigned DG_BOC    = 16,
  parameter int unsigned DG_BAT_OC = 1024,
  parameter int unsigned DG_MID    = 128,
  parameter int unsigned DG_REV    = 16,
  parameter int unsigned DG_SC     = 4,
  parameter int unsigned DG_TS     = 200000,
  parameter int unsigned HIC_WAIT  = 200000,
  parameter int unsigned HIC_RST   = 800000,
  parameter int unsigned TRIP_W    = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              bus_ov_i,
  input  logic              bus_oc_i,
  input  logic              bat_oc_i,
  input  logic              drop_ov_i,
  input  logic              bat_ov_i,
  input  logic              out_ov_i,
  input  logic              rev_cur_i,
  input  logic              short_i,
  input  logic              ts_bus_i,
  input  logic              ts_bat_i,
  input  logic              ov_long_i,
  input  logic              hiccup_en_i,
  input  logic              host_en_i,
  input  logic [9:0]        evt_clr_i,
  input  logic [9:0]        evt_mask_i,
  output logic              sw_en_o,
  output logic [9:0]        evt_o,
  output logic              irq_o,
  output logic [TRIP_W-1:0] trip_cnt_o
);
  localparam int unsigned DG_W = $clog2(DG_BOV_S + DG_BOV_L + DG_BOC + DG_BAT_OC
                                        + DG_MID + DG_REV + DG_SC + DG_TS + 1);

  fault_vec_t raw, qual, qual_q, rise, latch_sel;
  logic hic_wait, hic_retry, hic_trip, any_latch, en_q;

  assign raw = {ts_bat_i, ts_bus_i, short_i, rev_cur_i, out_ov_i,
                bat_ov_i, drop_ov_i, bat_oc_i, bus_oc_i, bus_ov_i};

  for (genvar g = 0; g < NFLT; g++) begin : g_dg
    localparam int unsigned LIM =
      (g == int'(F_BUS_OC))  ? DG_BOC    :
      (g == int'(F_BAT_OC))  ? DG_BAT_OC :
      (g == int'(F_REV))     ? DG_REV    :
      (g == int'(F_SHORT))   ? DG_SC     :
      (g >= int'(F_TS_BUS))  ? DG_TS     : DG_MID;
    logic [DG_W-1:0] lim;
    logic            hold;

    if (g == int'(F_BUS_OV)) begin : g_sel
      assign lim = ov_long_i ? DG_W'(DG_BOV_L) : DG_W'(DG_BOV_S);
    end else begin : g_fix
      assign lim = DG_W'(LIM);
    end

    if (g == int'(F_BUS_OC)) begin : g_hold
      assign hold = hic_wait;
    end else begin : g_free
      assign hold = 1'b0;
    end

    fault_deglitch #(.CNT_W(DG_W)) u_dg (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .tick_i (tick_i),
      .raw_i  (raw[g]),
      .hold_i (hold),
      .limit_i(lim),
      .qual_o (qual[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) qual_q <= '0;
    else         qual_q <= qual;
  end

  assign rise      = qual & ~qual_q;
  assign latch_sel = hiccup_en_i ? ~(fault_vec_t'(1) << F_BUS_OC) : '1;
  assign any_latch = |(qual & latch_sel);
  assign hic_trip  = hiccup_en_i && rise[F_BUS_OC];

  fault_hiccup #(
    .WAIT_TICKS (HIC_WAIT),
    .QUIET_TICKS(HIC_RST),
    .TRIP_W     (TRIP_W)
  ) u_hic (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .trip_i    (hic_trip),
    .abort_i   (any_latch),
    .wait_o    (hic_wait),
    .retry_o   (hic_retry),
    .trip_cnt_o(trip_cnt_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                   en_q <= 1'b0;
    else if (any_latch || hic_trip)                en_q <= 1'b0;
    else if (hic_retry)                            en_q <= 1'b1;
    else if (host_en_i && !(|qual) && !hic_wait)   en_q <= 1'b1;
  end

  fault_events #(.N(NFLT)) u_evt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (rise),
    .clr_i (evt_clr_i),
    .mask_i(evt_mask_i),
    .evt_o (evt_o),
    .irq_o (irq_o)
  );

  assign sw_en_o = en_q;
endmodule

// File: rtl/fault_guard_chk.sv
module fault_guard_chk #(
  parameter int unsigned TRIP_W = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [9:0]        qual_i,
  input logic              wait_i,
  input logic              host_en_i,
  input logic              sw_en_i,
  input logic [9:0]        evt_i,
  input logic [9:0]        clr_i,
  input logic [9:0]        mask_i,
  input logic              irq_i,
  input logic [TRIP_W-1:0] trip_cnt_i
);
  p_fault_off_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|qual_i) |=> !sw_en_i);

  p_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((evt_i & $past(evt_i & ~clr_i)) == $past(evt_i & ~clr_i)));

  p_masked_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&mask_i) |-> !irq_i);

  p_enable_cause_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sw_en_i) |-> ($past(host_en_i) || $past(wait_i)));

  p_wait_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wait_i |-> !sw_en_i);

  p_trip_mono_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((trip_cnt_i == '0) || (trip_cnt_i >= $past(trip_cnt_i))));
endmodule

bind fault_guard fault_guard_chk #(.TRIP_W(TRIP_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .qual_i    (qual),
  .wait_i    (hic_wait),
  .host_en_i (host_en_i),
  .sw_en_i   (sw_en_o),
  .evt_i     (evt_o),
  .clr_i     (evt_clr_i),
  .mask_i    (evt_mask_i),
  .irq_i     (irq_o),
  .trip_cnt_i(trip_cnt_o)
);

// File: tb/test_fault_guard.sv
module test_fault_guard;
  localparam int CLK_PERIOD = 10;
  localparam int BOV_S = 3, BOV_L = 12, BOC = 4, BAT_OC = 20, MID = 8;
  localparam int REV = 5, SC = 2, TS = 30, HWAIT = 40, HRST = 100;

  logic clk = 0, rst_n = 0, tick = 1;
  logic [9:0] raw = '0, clr = '0, mask = '0;
  logic ov_long = 0, hic_en = 0, host_en = 0;
  logic sw_en, irq;
  logic [9:0] evt;
  logic [2:0] trips;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fault_guard #(
    .DG_BOV_S(BOV_S), .DG_BOV_L(BOV_L), .DG_BOC(BOC), .DG_BAT_OC(BAT_OC),
    .DG_MID(MID), .DG_REV(REV), .DG_SC(SC), .DG_TS(TS),
    .HIC_WAIT(HWAIT), .HIC_RST(HRST), .TRIP_W(3)
  ) i_fault_guard (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick),
    .bus_ov_i(raw[0]), .bus_oc_i(raw[1]), .bat_oc_i(raw[2]), .drop_ov_i(raw[3]),
    .bat_ov_i(raw[4]), .out_ov_i(raw[5]), .rev_cur_i(raw[6]), .short_i(raw[7]),
    .ts_bus_i(raw[8]), .ts_bat_i(raw[9]),
    .ov_long_i(ov_long), .hiccup_en_i(hic_en), .host_en_i(host_en),
    .evt_clr_i(clr), .evt_mask_i(mask),
    .sw_en_o(sw_en), .evt_o(evt), .irq_o(irq), .trip_cnt_o(trips)
  );

  function automatic int lim_of(int i);
    case (i)
      0: return BOV_S;
      1: return BOC;
      2: return BAT_OC;
      3, 4, 5: return MID;
      6: return REV;
      7: return SC;
      default: return TS;
    endcase
  endfunction

  task automatic summary_and_end();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // advance n clock edges, return at a falling edge
  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_host();
    host_en = 1; step(1); host_en = 0;
  endtask

  task automatic clear_all();
    clr = '1; step(1); clr = '0;
  endtask

  task automatic t_reset();
    chk(sw_en == 0, "R1 sw_en", sw_en, 0);
    chk(evt == 0, "R1 evt", evt, 0);
    chk(irq == 0, "R1 irq", irq, 0);
    chk(trips == 0, "R1 trips", trips, 0);
  endtask

  task automatic t_enable();
    pulse_host();
    chk(sw_en == 1, "R7 host enable", sw_en, 1);
  endtask

  task automatic t_glitch();
    raw[3] = 1; step(MID - 1);
    raw[3] = 0; step(1);
    raw[3] = 1; step(MID - 1);
    raw[3] = 0; step(2);
    chk(sw_en == 1, "R2 broken flag keeps switch", sw_en, 1);
    chk(evt[3] == 0, "R2 broken flag no event", evt[3], 0);
  endtask

  task automatic t_trip_each();
    for (int i = 0; i < 10; i++) begin
      pulse_host();
      raw[i] = 1; step(lim_of(i));
      chk(sw_en == 1, "R3 not yet qualified", i, lim_of(i));
      chk(evt[i] == 0, "R5 no event before qualify", evt[i], 0);
      step(1);
      chk(sw_en == 0, "R4 switch off after qualify", sw_en, 0);
      chk(evt == (10'(1) << i), "R5 event bit position", evt, 1 << i);
      raw[i] = 0; step(1);
      clr = 10'(1) << i; step(1); clr = '0;
      chk(evt == 0, "R5 w1c clear", evt, 0);
    end
  endtask

  task automatic t_ov_long();
    ov_long = 1; pulse_host();
    raw[0] = 1; step(BOV_L);
    chk(sw_en == 1, "R3 long ovp not yet", sw_en, 1);
    step(1);
    chk(sw_en == 0, "R3 long ovp trip", sw_en, 0);
    raw[0] = 0; ov_long = 0; step(1); clear_all();
  endtask

  task automatic t_irq();
    pulse_host();
    raw[6] = 1; step(REV + 1); raw[6] = 0; step(1);
    chk(irq == 1, "R6 irq on event", irq, 1);
    mask = 10'h040; step(1);
    chk(irq == 0, "R6 masked", irq, 0);
    mask = 10'h3bf; step(1);
    chk(irq == 1, "R6 other mask bits", irq, 1);
    mask = '0; clear_all();
    chk(irq == 0, "R6 irq cleared", irq, 0);
  endtask

  task automatic t_latch();
    pulse_host();
    raw[4] = 1; step(MID + 1);
    pulse_host();
    chk(sw_en == 0, "R7 host pulse ignored under fault", sw_en, 0);
    raw[4] = 0; step(1);
    chk(sw_en == 0, "R7 stays latched off", sw_en, 0);
    pulse_host();
    chk(sw_en == 1, "R7 host re-enable", sw_en, 1);
    clear_all();
  endtask

  task automatic t_tick_gate();
    tick = 0; raw[7] = 1; step(20);
    chk(sw_en == 1, "R10 no count without tick", sw_en, 1);
    tick = 1; step(SC + 1);
    chk(sw_en == 0, "R10 count resumes", sw_en, 0);
    raw[7] = 0; step(1); clear_all(); pulse_host();
  endtask

  task automatic t_hiccup();
    hic_en = 1;
    chk(sw_en == 1, "R8 start enabled", sw_en, 1);
    raw[1] = 1; step(BOC + 1);
    chk(sw_en == 0, "R8 trip off", sw_en, 0);
    chk(trips == 1, "R9 first trip", trips, 1);
    raw[1] = 0;
    step(5); pulse_host();
    chk(sw_en == 0, "R7 host pulse ignored in wait", sw_en, 0);
    step(HWAIT - 7);
    chk(sw_en == 0, "R8 still waiting", sw_en, 0);
    step(1);
    chk(sw_en == 1, "R8 auto retry", sw_en, 1);
    raw[1] = 1; step(BOC + 1); raw[1] = 0;
    chk(trips == 2, "R9 second trip", trips, 2);
    step(HRST - 1);
    chk(trips == 2, "R9 before quiet end", trips, 2);
    step(1);
    chk(trips == 0, "R9 quiet clear", trips, 0);
    chk(sw_en == 1, "R8 re-enabled after second wait", sw_en, 1);
    hic_en = 0; clear_all();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary_and_end();
  end

  initial begin
    step(2);
    t_reset();
    rst_n = 1; step(1);
    t_reset();
    t_enable();
    t_glitch();
    t_trip_each();
    t_ov_long();
    t_irq();
    t_latch();
    t_tick_gate();
    t_hiccup();
    summary_and_end();
  end
endmodule